// File: doc/BRIEF.md
# Privilege-Gated Counter Register File

This block holds the programmable state of a performance monitor: a main control word, a secondary control word and six 64-bit event counters. Software reaches it through one request port that carries a read strobe, a write strobe, a register index, write data and a flag saying whether the request comes from user mode. Privileged requests see and change every bit of every register. User-mode requests are screened by a 2-bit access-control field held in the main control word, and the screening rules differ between reads and writes.

A user-mode request that the field forbids is answered with a fault code instead of data, and the registers are left as they were. An allowed user-mode request to a control word only sees the bits that user mode is entitled to see, and a user-mode write to a control word replaces only those bits. Counters are addressed through two windows, one for each mode, that lead to the same storage. Every response (read data and fault code) appears on the cycle after the request.

Top module: `pmu_access_regfile`

## Requirements
- R1: After reset every register holds 0, the access-control field therefore reads 00, and both response outputs are 0.
- R2: A privileged request (req_user low) to a mapped index reads or writes the full 64-bit value of the register and never faults; the main control word is at index 0x00, the secondary control word at index 0x01, privileged counters 1 to 6 at indices 0x21 to 0x26.
- R3: The access-control field is bits 19:18 of the main control word; a user-mode read of either control word or of counters 1 to 4 raises fault code 01 (facility unavailable) when the field is 01 and is allowed for 00, 10 and 11.
- R4: A user-mode write is allowed only when the field is 10 or 11; with field 00 it raises fault code 10 (illegal register) and with field 01 it raises fault code 01.
- R5: With the field at 11, every user-mode read or write of counter 5 or counter 6 raises fault code 01; with any other field value these two counters follow R3 and R4.
- R6: A user-mode read of the main control word returns only bits 31 (freeze counters), 26 (alert enable) and 7 (alert occurred), and a user-mode read of the secondary control word returns only the per-counter user-freeze bits 0, 8, 16, 24, 32 and 40; every other bit reads 0.
- R7: An allowed user-mode write to a control word replaces only the bits listed in R6 with the write data; every other bit, the access-control field included, keeps its value.
- R8: In user mode counters 1 to 6 are reached at indices 0x11 to 0x16, 0x10 below the privileged indices, and these reach the same counters with full 64-bit data.
- R9: rsp_rdata and rsp_fault reflect the request of the previous cycle only; a fault lasts one cycle, a faulting read returns 0, and a faulting request changes no register.
- R10: An index outside the window of the requesting mode (including a privileged counter index used in user mode and the reverse) reads 0, ignores writes and raises no fault.
- R11: When both strobes are high the request is handled as a write under the write rules, and rsp_rdata returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_idx | input | 6 | Register index |
| req_wdata | input | 64 | Write data |
| req_user | input | 1 | High for a user-mode request |
| rsp_rdata | output | 64 | Read data, one cycle after the request |
| rsp_fault | output | 2 | Fault code, one cycle after the request: 00 none, 01 facility unavailable, 10 illegal register |

## Verification
The assertions assume that the request inputs are held low while reset is asserted, so that nothing queued during reset appears as a response, and that the strobes, index, data and mode flag are stable across each rising edge. The bench changes inputs only on falling edges and keeps the strobes low through reset. It drives the access-control field through all four values by privileged writes, then sweeps user-mode reads and writes over both control words, all six counters, the opposite-mode windows and an unused index, including both strobes at once.

// File: rtl/pmu_acc_pkg.sv
package pmu_acc_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_UNAVAIL = 2'b01,
      FLT_ILLEGAL = 2'b10
   } fault_e;

   typedef enum logic [1:0] {
      RK_NONE = 2'b00,
      RK_MAIN = 2'b01,
      RK_SEC  = 2'b10,
      RK_CNT  = 2'b11
   } reg_kind_e;

   // One set bit every STRIDE positions, NBITS of them, starting at bit 0.
   function automatic logic [63:0] stride_mask(input int nbits, input int stride);
      logic [63:0] m;
      m = '0;
      for (int k = 0; k < nbits; k++) begin
         if (k * stride < 64) m[k*stride] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/pmu_acc_decode.sv
module pmu_acc_decode
   import pmu_acc_pkg::*;
#(
   parameter int IDX_W         = 6,
   parameter int NUM_CNT       = 6,
   parameter int MAIN_IDX      = 0,
   parameter int SEC_IDX       = 1,
   parameter int PRIV_CNT_BASE = 33,
   parameter int USER_CNT_OFS  = 16,
   localparam int CSEL_W       = $clog2(NUM_CNT)
)(
   input  logic [IDX_W-1:0]   idx,
   input  logic               user,
   output reg_kind_e          kind,
   output logic [NUM_CNT-1:0] cnt_hit,
   output logic [CSEL_W-1:0]  cnt_sel
);

   localparam int USER_CNT_BASE = PRIV_CNT_BASE - USER_CNT_OFS;

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_win
      localparam logic [IDX_W-1:0] P_IDX = IDX_W'(PRIV_CNT_BASE + k);
      localparam logic [IDX_W-1:0] U_IDX = IDX_W'(USER_CNT_BASE + k);
      assign cnt_hit[k] = user ? (idx == U_IDX) : (idx == P_IDX);
   end

   always_comb begin
      cnt_sel = '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (cnt_hit[k]) cnt_sel = CSEL_W'(k);
      end
   end

   always_comb begin
      if (idx == IDX_W'(MAIN_IDX))     kind = RK_MAIN;
      else if (idx == IDX_W'(SEC_IDX)) kind = RK_SEC;
      else if (|cnt_hit)               kind = RK_CNT;
      else                             kind = RK_NONE;
   end

endmodule

// File: rtl/pmu_acc_policy.sv
module pmu_acc_policy
   import pmu_acc_pkg::*;
#(
   parameter int NUM_CNT  = 6,
   parameter int NUM_EXCL = 2,
   localparam int CSEL_W  = $clog2(NUM_CNT)
)(
   input  logic              rd,
   input  logic              wr,
   input  logic              user,
   input  reg_kind_e         kind,
   input  logic [CSEL_W-1:0] cnt_sel,
   input  logic [1:0]        acc_field,
   output logic              grant_rd,
   output logic              grant_wr,
   output fault_e            fault
);

   logic excl_hit;
   logic ok;

   if (NUM_EXCL == 0) begin : g_no_excl
      assign excl_hit = 1'b0;
   end else begin : g_excl
      localparam int FIRST_EXCL = NUM_CNT - NUM_EXCL;
      assign excl_hit = (kind == RK_CNT) && (int'(cnt_sel) >= FIRST_EXCL);
   end

   always_comb begin
      ok    = 1'b0;
      fault = FLT_NONE;
      if ((rd || wr) && kind != RK_NONE) begin
         if (!user) begin
            ok = 1'b1;
         end else if (excl_hit && acc_field == 2'b11) begin
            fault = FLT_UNAVAIL;
         end else if (wr) begin
            if (acc_field[1])      ok    = 1'b1;
            else if (acc_field[0]) fault = FLT_UNAVAIL;
            else                   fault = FLT_ILLEGAL;
         end else begin
            if (acc_field == 2'b01) fault = FLT_UNAVAIL;
            else                    ok    = 1'b1;
         end
      end
   end

   assign grant_wr = ok && wr;
   assign grant_rd = ok && rd && !wr;

endmodule

// File: rtl/pmu_acc_store.sv
module pmu_acc_store #(
   parameter int DATA_W                 = 64,
   parameter int NUM_CNT                = 6,
   parameter logic [DATA_W-1:0] MAIN_UMASK = '0,
   parameter logic [DATA_W-1:0] SEC_UMASK  = '0
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            user,
   input  logic [DATA_W-1:0]               wdata,
   input  logic                            we_main,
   input  logic                            we_sec,
   input  logic [NUM_CNT-1:0]              we_cnt,
   output logic [DATA_W-1:0]               main_q,
   output logic [DATA_W-1:0]               sec_q,
   output logic [NUM_CNT-1:0][DATA_W-1:0]  cnt_q
);

   function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                               input logic [DATA_W-1:0] new_v,
                                               input logic [DATA_W-1:0] msk);
      return (old_v & ~msk) | (new_v & msk);
   endfunction

   logic [DATA_W-1:0] main_d, sec_d;

   assign main_d = user ? merge(main_q, wdata, MAIN_UMASK) : wdata;
   assign sec_d  = user ? merge(sec_q,  wdata, SEC_UMASK)  : wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)       main_q <= '0;
      else if (we_main) main_q <= main_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      sec_q <= '0;
      else if (we_sec) sec_q <= sec_d;
   end

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)         cnt_q[k] <= '0;
         else if (we_cnt[k]) cnt_q[k] <= wdata;
      end
   end

endmodule

// File: rtl/pmu_acc_rdpath.sv
module pmu_acc_rdpath
   import pmu_acc_pkg::*;
#(
   parameter int DATA_W                 = 64,
   parameter int NUM_CNT                = 6,
   parameter logic [DATA_W-1:0] MAIN_UMASK = '0,
   parameter logic [DATA_W-1:0] SEC_UMASK  = '0,
   localparam int CSEL_W                = $clog2(NUM_CNT)
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           grant_rd,
   input  logic                           user,
   input  reg_kind_e                      kind,
   input  logic [CSEL_W-1:0]              cnt_sel,
   input  fault_e                         fault,
   input  logic [DATA_W-1:0]              main_q,
   input  logic [DATA_W-1:0]              sec_q,
   input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0]              rdata,
   output logic [1:0]                     fault_code
);

   logic [DATA_W-1:0] main_vis, sec_vis, sel_v;

   assign main_vis = user ? (main_q & MAIN_UMASK) : main_q;
   assign sec_vis  = user ? (sec_q  & SEC_UMASK)  : sec_q;

   always_comb begin
      unique case (kind)
         RK_MAIN: sel_v = main_vis;
         RK_SEC:  sel_v = sec_vis;
         RK_CNT:  sel_v = cnt_q[cnt_sel];
         default: sel_v = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata      <= '0;
         fault_code <= FLT_NONE;
      end else begin
         rdata      <= grant_rd ? sel_v : '0;
         fault_code <= fault;
      end
   end

endmodule

// File: rtl/pmu_access_regfile.sv
module pmu_access_regfile
   import pmu_acc_pkg::*;
#(
   parameter int DATA_W        = 64,
   parameter int IDX_W         = 6,
   parameter int NUM_CNT       = 6,
   parameter int NUM_EXCL      = 2,
   parameter int MAIN_IDX      = 0,
   parameter int SEC_IDX       = 1,
   parameter int PRIV_CNT_BASE = 33,
   parameter int USER_CNT_OFS  = 16,
   parameter int ACC_LSB       = 18,
   parameter int SEC_STRIDE    = 8,
   parameter logic [DATA_W-1:0] MAIN_UMASK = DATA_W'(64'h0000_0000_8400_0080),
   parameter logic [DATA_W-1:0] SEC_UMASK  = DATA_W'(stride_mask(NUM_CNT, SEC_STRIDE))
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_rd,
   input  logic              req_wr,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_user,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [1:0]        rsp_fault
);

   localparam int CSEL_W = $clog2(NUM_CNT);

   if (NUM_CNT < 2)                                begin : g_chk_cnt   $error("NUM_CNT must be at least 2");          end
   if (NUM_EXCL > NUM_CNT)                         begin : g_chk_excl  $error("NUM_EXCL exceeds NUM_CNT");            end
   if (ACC_LSB + 2 > DATA_W)                       begin : g_chk_acc   $error("access field outside the word");       end
   if (PRIV_CNT_BASE < USER_CNT_OFS)               begin : g_chk_ofs   $error("user counter window below index 0");   end
   if (PRIV_CNT_BASE + NUM_CNT > (1 << IDX_W))     begin : g_chk_idx   $error("counter window exceeds index range");  end
   if (MAIN_UMASK[ACC_LSB +: 2] != 2'b00)          begin : g_chk_mask  $error("user mask must not expose the field"); end

   reg_kind_e           kind;
   logic [NUM_CNT-1:0]  cnt_hit;
   logic [CSEL_W-1:0]   cnt_sel;
   logic                grant_rd, grant_wr;
   fault_e              fault;
   logic [DATA_W-1:0]   main_q, sec_q;
   logic [NUM_CNT-1:0][DATA_W-1:0] cnt_q;

   pmu_acc_decode #(
      .IDX_W(IDX_W), .NUM_CNT(NUM_CNT), .MAIN_IDX(MAIN_IDX), .SEC_IDX(SEC_IDX),
      .PRIV_CNT_BASE(PRIV_CNT_BASE), .USER_CNT_OFS(USER_CNT_OFS)
   ) u_dec (
      .idx(req_idx), .user(req_user), .kind(kind), .cnt_hit(cnt_hit), .cnt_sel(cnt_sel)
   );

   pmu_acc_policy #(.NUM_CNT(NUM_CNT), .NUM_EXCL(NUM_EXCL)) u_pol (
      .rd(req_rd), .wr(req_wr), .user(req_user), .kind(kind), .cnt_sel(cnt_sel),
      .acc_field(main_q[ACC_LSB +: 2]),
      .grant_rd(grant_rd), .grant_wr(grant_wr), .fault(fault)
   );

   pmu_acc_store #(
      .DATA_W(DATA_W), .NUM_CNT(NUM_CNT), .MAIN_UMASK(MAIN_UMASK), .SEC_UMASK(SEC_UMASK)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .user(req_user), .wdata(req_wdata),
      .we_main(grant_wr && kind == RK_MAIN),
      .we_sec(grant_wr && kind == RK_SEC),
      .we_cnt(cnt_hit & {NUM_CNT{grant_wr}}),
      .main_q(main_q), .sec_q(sec_q), .cnt_q(cnt_q)
   );

   pmu_acc_rdpath #(
      .DATA_W(DATA_W), .NUM_CNT(NUM_CNT), .MAIN_UMASK(MAIN_UMASK), .SEC_UMASK(SEC_UMASK)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .grant_rd(grant_rd), .user(req_user), .kind(kind),
      .cnt_sel(cnt_sel), .fault(fault), .main_q(main_q), .sec_q(sec_q), .cnt_q(cnt_q),
      .rdata(rsp_rdata), .fault_code(rsp_fault)
   );

endmodule

// File: rtl/pmu_acc_checker.sv
module pmu_acc_checker #(
   parameter int DATA_W  = 64,
   parameter int ACC_LSB = 18,
   parameter logic [DATA_W-1:0] MAIN_UMASK = '0,
   parameter logic [DATA_W-1:0] SEC_UMASK  = '0
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_rd,
   input logic              req_wr,
   input logic              req_user,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic [1:0]        rsp_fault,
   input logic [DATA_W-1:0] main_q,
   input logic [DATA_W-1:0] sec_q
);

   p_priv_never_faults_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_user || !(req_rd || req_wr)) |=> rsp_fault == 2'b00);

   p_illegal_needs_field00_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault == 2'b10 |-> $past(req_wr && main_q[ACC_LSB +: 2] == 2'b00));

   p_code_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault != 2'b11);

   p_fault_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault != 2'b00 |-> rsp_rdata == '0);

   p_fault_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault != 2'b00 |-> ($stable(main_q) && $stable(sec_q)));

   p_user_main_outside_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_user && req_wr) |=> ((main_q & ~MAIN_UMASK) == ($past(main_q) & ~MAIN_UMASK)));

   p_user_sec_outside_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_user && req_wr) |=> ((sec_q & ~SEC_UMASK) == ($past(sec_q) & ~SEC_UMASK)));

   p_write_returns_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr || !req_rd) |=> rsp_rdata == '0);

endmodule

bind pmu_access_regfile pmu_acc_checker #(
   .DATA_W(DATA_W), .ACC_LSB(ACC_LSB), .MAIN_UMASK(MAIN_UMASK), .SEC_UMASK(SEC_UMASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_user(req_user),
   .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .main_q(main_q), .sec_q(sec_q)
);

// File: tb/pmu_access_regfile_test.sv
module pmu_access_regfile_test;

   localparam logic [63:0] U_MAIN = 64'h0000_0000_8400_0080;
   localparam logic [63:0] U_SEC  = 64'h0000_0101_0101_0101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_rd = 1'b0, req_wr = 1'b0, req_user = 1'b0;
   logic [5:0]  req_idx = '0;
   logic [63:0] req_wdata = '0;
   logic [63:0] rsp_rdata;
   logic [1:0]  rsp_fault;

   int checks = 0;
   int errors = 0;

   logic [63:0] m_main, m_sec;
   logic [63:0] m_cnt [6];

   always #5 clk = ~clk;

   pmu_access_regfile uut (
      .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_idx(req_idx),
      .req_wdata(req_wdata), .req_user(req_user), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault)
   );

   task automatic compare(input string tag, input logic [1:0] ef, input logic [63:0] er);
      checks++;
      if (rsp_fault !== ef || rsp_rdata !== er) begin
         errors++;
         $display("FAIL %s: fault=%b rdata=%h expected fault=%b rdata=%h",
                  tag, rsp_fault, rsp_rdata, ef, er);
      end
   endtask

   // Behavioural reference: decides the response and updates the model registers.
   task automatic model(input bit rd, input bit wr, input logic [5:0] idx,
                        input logic [63:0] wd, input bit usr,
                        output logic [1:0] ef, output logic [63:0] er);
      int c;
      bit is_main, is_sec, mapped;
      logic [1:0] fld;
      c = -1;
      is_main = (idx == 6'h00);
      is_sec  = (idx == 6'h01);
      if (usr && idx >= 6'h11 && idx <= 6'h16)  c = int'(idx) - 'h11;
      if (!usr && idx >= 6'h21 && idx <= 6'h26) c = int'(idx) - 'h21;
      mapped = is_main || is_sec || (c >= 0);
      fld = m_main[19:18];
      ef = 2'b00;
      er = '0;
      if (!(rd || wr) || !mapped) return;
      if (usr) begin
         if (c >= 4 && fld == 2'b11) ef = 2'b01;
         else if (wr)                ef = (fld == 2'b00) ? 2'b10 : (fld == 2'b01) ? 2'b01 : 2'b00;
         else                        ef = (fld == 2'b01) ? 2'b01 : 2'b00;
      end
      if (ef != 2'b00) return;
      if (wr) begin
         if (is_main)     m_main = usr ? ((m_main & ~U_MAIN) | (wd & U_MAIN)) : wd;
         else if (is_sec) m_sec  = usr ? ((m_sec & ~U_SEC) | (wd & U_SEC)) : wd;
         else             m_cnt[c] = wd;
      end else begin
         if (is_main)     er = usr ? (m_main & U_MAIN) : m_main;
         else if (is_sec) er = usr ? (m_sec & U_SEC) : m_sec;
         else             er = m_cnt[c];
      end
   endtask

   task automatic req(input bit rd, input bit wr, input logic [5:0] idx,
                      input logic [63:0] wd, input bit usr, input string tag);
      logic [1:0]  ef;
      logic [63:0] er;
      model(rd, wr, idx, wd, usr, ef, er);
      req_rd = rd; req_wr = wr; req_idx = idx; req_wdata = wd; req_user = usr;
      @(posedge clk);
      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0;
      compare(tag, ef, er);
   endtask

   task automatic set_field(input logic [1:0] f);
      logic [63:0] v;
      v = m_main;
      v[19:18] = f;
      req(0, 1, 6'h00, v, 0, "R2");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_main = '0; m_sec = '0;
      for (int k = 0; k < 6; k++) m_cnt[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: outputs and registers cleared
      compare("R1", 2'b00, '0);
      req(1, 0, 6'h00, '0, 0, "R1");
      req(1, 0, 6'h01, '0, 0, "R1");
      for (int k = 0; k < 6; k++) req(1, 0, 6'(6'h21 + k), '0, 0, "R1");

      // R2: full-width privileged access, field ends at 00
      req(0, 1, 6'h00, 64'hFFFF_FFFF_FFF3_FFFF, 0, "R2");
      req(0, 1, 6'h01, 64'hA5A5_5A5A_F0F0_0F0F, 0, "R2");
      for (int k = 0; k < 6; k++) req(0, 1, 6'(6'h21 + k), 64'h1111_0000_0000_0001 * (k + 1), 0, "R2");
      req(1, 0, 6'h00, '0, 0, "R2");
      req(1, 0, 6'h01, '0, 0, "R2");
      for (int k = 0; k < 6; k++) req(1, 0, 6'(6'h21 + k), '0, 0, "R2");

      // Field 00: user reads masked (R3, R6), user writes illegal (R4, R9)
      req(1, 0, 6'h00, '0, 1, "R6");
      req(1, 0, 6'h01, '0, 1, "R6");
      req(1, 0, 6'h15, '0, 1, "R3");
      req(0, 1, 6'h00, '0, 1, "R4");
      req(0, 0, 6'h00, '0, 0, "R9");
      req(0, 1, 6'h12, 64'hDEAD, 1, "R4");
      req(1, 0, 6'h22, '0, 0, "R9");

      // Field 01: everything user-side unavailable
      set_field(2'b01);
      req(1, 0, 6'h00, '0, 1, "R3");
      req(1, 0, 6'h11, '0, 1, "R3");
      req(0, 1, 6'h01, '1, 1, "R4");
      req(0, 1, 6'h16, '1, 1, "R4");
      req(1, 0, 6'h01, '0, 0, "R9");

      // Field 10: masked read-modify-write and user counter window
      set_field(2'b10);
      req(0, 1, 6'h00, 64'h0, 1, "R7");
      req(1, 0, 6'h00, '0, 0, "R7");
      req(0, 1, 6'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7");
      req(1, 0, 6'h00, '0, 0, "R7");
      req(0, 1, 6'h01, 64'h0, 1, "R7");
      req(1, 0, 6'h01, '0, 0, "R7");
      for (int k = 0; k < 6; k++) req(0, 1, 6'(6'h11 + k), 64'hC000_0000_0000_0100 + k, 1, "R8");
      for (int k = 0; k < 6; k++) req(1, 0, 6'(6'h21 + k), '0, 0, "R8");
      req(1, 0, 6'h15, '0, 1, "R5");

      // Field 11: counters 5 and 6 excluded from user mode
      set_field(2'b11);
      req(1, 0, 6'h15, '0, 1, "R5");
      req(1, 0, 6'h16, '0, 1, "R5");
      req(0, 1, 6'h15, '1, 1, "R5");
      req(0, 1, 6'h16, '1, 1, "R5");
      req(1, 0, 6'h25, '0, 0, "R5");
      req(1, 0, 6'h26, '0, 0, "R5");
      req(0, 1, 6'h14, 64'h7777, 1, "R4");
      req(1, 0, 6'h14, '0, 1, "R3");

      // R10: opposite-mode windows and an unused index
      req(1, 0, 6'h21, '0, 1, "R10");
      req(0, 1, 6'h21, '1, 1, "R10");
      req(1, 0, 6'h11, '0, 0, "R10");
      req(0, 1, 6'h11, '1, 0, "R10");
      req(0, 1, 6'h3F, '1, 0, "R10");
      req(1, 0, 6'h3F, '0, 1, "R10");
      req(1, 0, 6'h21, '0, 0, "R10");

      // R11: both strobes act as a write
      req(1, 1, 6'h23, 64'h0BAD_F00D, 0, "R11");
      req(1, 0, 6'h23, '0, 0, "R11");
      set_field(2'b00);
      req(1, 1, 6'h00, '1, 1, "R11");
      req(0, 0, 6'h00, '0, 1, "R9");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule